// File: doc/BRIEF.md
# Cascaded Switch-Register Serial Programmer

This block is the host side of a chain of serially loaded switch controllers. Each controller holds one byte in a shift stage and one byte in a latch. The latch drives eight switches. All controllers share one serial clock, one active-low latch strobe and one clear line. The serial output of each controller feeds the serial input of the next one along the chain. The block accepts a parallel map covering the whole chain. It streams the map out serially while the strobe stays inactive, then gives one strobe pulse so that every controller takes its new byte on the same edge.

A second request raises the clear line for a set number of cycles. This opens every switch in the chain and sends no serial data. The serial clock half-period, the gap from the last clock fall to the strobe, the strobe width and the clear width are parameters counted in system clock cycles. These values are chosen so that the serial clock stays within the controllers' rated rate and the minimum strobe and clear timings are met. The map is packed so that its top byte belongs to the controller farthest from the host. That byte leaves first, and the byte for the nearest controller leaves last.

Top module: `swchain_host`

## Requirements
- R1: After reset, ser_clk is 0, latch_n is 1, clr_out is 0 and busy is 0.
- R2: An accepted load sends exactly N_DEV*8 rising ser_clk edges. The bit presented at the k-th rising edge is load_map[N_DEV*8-k], so the map goes out from its top bit down. The top byte belongs to the farthest controller, and each byte goes out most significant bit first.
- R3: ser_clk stays high for exactly HALF_CYC cycles and low for at least HALF_CYC cycles. ser_dat does not change while ser_clk is high.
- R4: latch_n stays 1 during the whole of the shifting. Each load ends with exactly one latch_n low pulse, lasting exactly LE_LOW cycles.
- R5: latch_n falls exactly LE_SETUP cycles after the last falling edge of ser_clk.
- R6: A clear request on an idle block raises clr_out for exactly CLR_HIGH cycles. During that time ser_clk stays 0 and latch_n stays 1.
- R7: A clear request that arrives during a load, or in the same cycle as an accepted load, is held until the load finishes. clr_out then rises in the same cycle that latch_n returns to 1, and busy stays 1 in between.
- R8: A load or clear request seen while busy is 1 is dropped. The exception is the clear during a load that R7 covers. A dropped request produces no serial clock, strobe or clear activity.
- R9: busy rises in the cycle after a request is accepted. It falls in the same cycle that the final latch_n or clr_out pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load_req | input | 1 | Single-cycle request to program the chain |
| load_map | input | N_DEV*8 | Switch map; top byte goes to the farthest controller |
| clear_req | input | 1 | Single-cycle request to open all switches |
| busy | output | 1 | High while a transfer or clear pulse is in progress |
| ser_clk | output | 1 | Shared serial clock, idles low |
| ser_dat | output | 1 | Serial data to the first controller |
| latch_n | output | 1 | Shared latch strobe, active low |
| clr_out | output | 1 | Shared clear line, active high |

## Verification
The assertions rely on requests being one-cycle pulses driven relative to the system clock. They also rely on every timing parameter being at least one. The stimulus drives requests on the falling system clock edge and holds each one for a single cycle. Requests meant to be dropped are issued only after busy has been seen high. Queued clears are injected both in the middle of shifting and together with the load request itself.

// File: rtl/swchain_pkg.sv
package swchain_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLK_LO,
    ST_CLK_HI,
    ST_SETUP,
    ST_LATCH,
    ST_CLEAR
  } sc_state_t;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/swchain_timer.sv
module swchain_timer #(
  parameter int TW   = 4,
  parameter int MAXV = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          done
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) < MAXV);

endmodule

// File: rtl/swchain_shifter.sv
module swchain_shifter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] map,
  input  logic         shift,
  output logic         msb,
  output logic         last
);

  localparam int BW = $clog2(W + 1);

  logic [W-1:0]  sh;
  logic [BW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      left <= '0;
    end else if (load) begin
      sh   <= map;
      left <= BW'(W);
    end else if (shift) begin
      sh   <= {sh[W-2:0], 1'b0};
      left <= left - 1'b1;
    end
  end

  assign msb  = sh[W-1];
  assign last = (left == BW'(1));

  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (rst)
    shift |-> left > BW'(1));

endmodule

// File: rtl/swchain_host.sv
module swchain_host
  import swchain_pkg::*;
#(
  parameter int N_DEV    = 3,
  parameter int DEV_BITS = 8,
  parameter int HALF_CYC = 2,
  parameter int LE_SETUP = 3,
  parameter int LE_LOW   = 2,
  parameter int CLR_HIGH = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load_req,
  input  logic [N_DEV*DEV_BITS-1:0] load_map,
  input  logic                      clear_req,
  output logic                      busy,
  output logic                      ser_clk,
  output logic                      ser_dat,
  output logic                      latch_n,
  output logic                      clr_out
);

  localparam int W    = N_DEV * DEV_BITS;
  localparam int MAXP = max_of4(HALF_CYC, LE_SETUP, LE_LOW, CLR_HIGH);
  localparam int TW   = $clog2(MAXP + 1);

  sc_state_t     st_q, st_n;
  logic          pend_q;
  logic          t_load, t_done;
  logic [TW-1:0] t_val;
  logic          sh_load, sh_shift, sh_last;
  logic          busy_q, sclk_q, le_n_q, clr_q;

  swchain_timer #(.TW(TW), .MAXV(MAXP)) u_timer (
    .clk (clk),
    .rst (rst),
    .load(t_load),
    .val (t_val),
    .done(t_done)
  );

  swchain_shifter #(.W(W)) u_shift (
    .clk  (clk),
    .rst  (rst),
    .load (sh_load),
    .map  (load_map),
    .shift(sh_shift),
    .msb  (ser_dat),
    .last (sh_last)
  );

  always_comb begin
    st_n     = st_q;
    t_load   = 1'b0;
    t_val    = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (load_req) begin
          st_n    = ST_CLK_LO;
          t_load  = 1'b1;
          t_val   = TW'(HALF_CYC - 1);
          sh_load = 1'b1;
        end else if (clear_req) begin
          st_n   = ST_CLEAR;
          t_load = 1'b1;
          t_val  = TW'(CLR_HIGH - 1);
        end
      end
      ST_CLK_LO: begin
        if (t_done) begin
          st_n   = ST_CLK_HI;
          t_load = 1'b1;
          t_val  = TW'(HALF_CYC - 1);
        end
      end
      ST_CLK_HI: begin
        if (t_done) begin
          t_load = 1'b1;
          if (sh_last) begin
            st_n  = ST_SETUP;
            t_val = TW'(LE_SETUP - 1);
          end else begin
            st_n     = ST_CLK_LO;
            t_val    = TW'(HALF_CYC - 1);
            sh_shift = 1'b1;
          end
        end
      end
      ST_SETUP: begin
        if (t_done) begin
          st_n   = ST_LATCH;
          t_load = 1'b1;
          t_val  = TW'(LE_LOW - 1);
        end
      end
      ST_LATCH: begin
        if (t_done) begin
          if (pend_q || clear_req) begin
            st_n   = ST_CLEAR;
            t_load = 1'b1;
            t_val  = TW'(CLR_HIGH - 1);
          end else begin
            st_n = ST_IDLE;
          end
        end
      end
      ST_CLEAR: begin
        if (t_done) st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      le_n_q <= 1'b1;
      clr_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      busy_q <= (st_n != ST_IDLE);
      sclk_q <= (st_n == ST_CLK_HI);
      le_n_q <= (st_n != ST_LATCH);
      clr_q  <= (st_n == ST_CLEAR);
      if (st_n == ST_CLEAR) begin
        pend_q <= 1'b0;
      end else if (clear_req && ((st_q != ST_IDLE && st_q != ST_CLEAR) ||
                                 (st_q == ST_IDLE && load_req))) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign busy    = busy_q;
  assign ser_clk = sclk_q;
  assign latch_n = le_n_q;
  assign clr_out = clr_q;

  assert_le_idle_shift_R4: assert property (@(posedge clk) disable iff (rst)
    ser_clk |-> latch_n);

  assert_dat_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_dat));

  assert_clr_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    clr_out |-> (!ser_clk && latch_n));

  assert_busy_cover_R9: assert property (@(posedge clk) disable iff (rst)
    (ser_clk || !latch_n || clr_out) |-> busy);

  assert_clr_after_le_R7: assert property (@(posedge clk) disable iff (rst)
    (!latch_n && pend_q) |=> (!latch_n || clr_out));

endmodule

// File: tb/test_swchain_host.sv
module test_swchain_host;

  localparam int CLK_PERIOD = 10;
  localparam int N_DEV    = 3;
  localparam int HALF_CYC = 2;
  localparam int LE_SETUP = 3;
  localparam int LE_LOW   = 2;
  localparam int CLR_HIGH = 4;
  localparam int W        = N_DEV * 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load_req = 1'b0;
  logic [W-1:0] load_map = '0;
  logic         clear_req = 1'b0;
  logic         busy, ser_clk, ser_dat, latch_n, clr_out;

  int n_chk = 0;
  int n_err = 0;
  bit done_flag = 1'b0;

  logic [W-1:0] exp_q[$];
  int clr_expected = 0;
  int clr_seen = 0;
  int loads_seen = 0;
  bit q_mode = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swchain_host #(
    .N_DEV(N_DEV), .DEV_BITS(8), .HALF_CYC(HALF_CYC),
    .LE_SETUP(LE_SETUP), .LE_LOW(LE_LOW), .CLR_HIGH(CLR_HIGH)
  ) i_swchain_host (
    .clk(clk), .rst(rst), .load_req(load_req), .load_map(load_map),
    .clear_req(clear_req), .busy(busy), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .latch_n(latch_n), .clr_out(clr_out)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  endtask

  // Monitor: samples on the falling system clock edge
  logic         p_sclk = 1'b0, p_le = 1'b1, p_clr = 1'b0, p_busy = 1'b0, p_dat = 1'b0;
  int           hi_run = 0, lo_run = 0, le_run = 0, clr_run = 0, gap = 0, nbits = 0;
  logic [W-1:0] cap = '0;
  bit           first_lo = 1'b1;

  always @(negedge clk) begin
    if (!rst) begin
      if (ser_clk && p_sclk)
        chk(ser_dat == p_dat, "R3 data moved while clock high", ser_dat, p_dat);
      if (ser_clk && !p_sclk) begin
        if (!first_lo)
          chk(lo_run >= HALF_CYC, "R3 clock low width", lo_run, HALF_CYC);
        first_lo = 1'b0;
        chk(latch_n == 1'b1, "R4 strobe high while shifting", latch_n, 1);
        cap = {cap[W-2:0], ser_dat};
        nbits++;
      end
      if (!ser_clk && p_sclk)
        chk(hi_run == HALF_CYC, "R3 clock high width", hi_run, HALF_CYC);
      if (!latch_n && p_le) begin
        chk(gap == LE_SETUP, "R5 clock-to-strobe gap", gap, LE_SETUP);
        loads_seen++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected strobe", 1, 0);
        end else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          chk(nbits == W, "R2 bit count", nbits, W);
          chk(cap == e, "R2 shifted map", cap, e);
        end
      end
      if (latch_n && !p_le)
        chk(le_run == LE_LOW, "R4 strobe low width", le_run, LE_LOW);
      if (clr_out && !p_clr) begin
        chk(busy == 1'b1, "R9 busy during clear", busy, 1);
        if (q_mode)
          chk(!p_le && latch_n, "R7 queued clear follows strobe", p_le, 0);
        clr_seen++;
      end
      if (clr_out)
        chk(!ser_clk && latch_n, "R6 quiet lines during clear", {ser_clk, latch_n}, 2'b01);
      if (!clr_out && p_clr)
        chk(clr_run == CLR_HIGH, "R6 clear width", clr_run, CLR_HIGH);
      if (!busy && p_busy)
        chk((!p_le || p_clr) && latch_n && !clr_out, "R9 busy fall at pulse end",
            {p_le, p_clr}, 2'b00);
      // run-length updates
      hi_run  = ser_clk ? hi_run + 1 : 0;
      lo_run  = ser_clk ? 0 : lo_run + 1;
      le_run  = latch_n ? 0 : le_run + 1;
      clr_run = clr_out ? clr_run + 1 : 0;
      gap     = ser_clk ? 0 : gap + 1;
      if (!latch_n) begin
        nbits = 0;
        first_lo = 1'b1;
      end
    end
    p_sclk = ser_clk; p_le = latch_n; p_clr = clr_out; p_busy = busy; p_dat = ser_dat;
  end

  task automatic pulse_req(input bit ld, input bit cl, input logic [W-1:0] m);
    load_map  = m;
    load_req  = ld;
    clear_req = cl;
    @(negedge clk);
    load_req  = 1'b0;
    clear_req = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_load(input logic [W-1:0] m);
    exp_q.push_back(m);
    pulse_req(1'b1, 1'b0, m);
    chk(busy == 1'b1, "R9 busy after accept", busy, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ser_clk == 0 && latch_n == 1 && clr_out == 0 && busy == 0, "R1 reset state",
        {ser_clk, latch_n, clr_out, busy}, 4'b0100);

    do_load(24'hA53C81); wait_idle();
    do_load(24'h000001); wait_idle();
    do_load(24'hFFFFFF); wait_idle();
    do_load(24'h800000); wait_idle();

    // R6 plain clear
    clr_expected++;
    pulse_req(1'b0, 1'b1, '0);
    wait_idle();

    // R7 clear queued mid-shift
    q_mode = 1'b1;
    do_load(24'h5A0F33);
    repeat (5) @(negedge clk);
    clr_expected++;
    pulse_req(1'b0, 1'b1, '0);
    wait_idle();

    // R7 clear together with load
    exp_q.push_back(24'h0123C4);
    clr_expected++;
    pulse_req(1'b1, 1'b1, 24'h0123C4);
    wait_idle();
    q_mode = 1'b0;

    // R8 load during load is dropped
    do_load(24'h6699AA);
    repeat (3) @(negedge clk);
    pulse_req(1'b1, 1'b0, 24'h111111);
    wait_idle();

    // R8 load and clear during clear are dropped
    clr_expected++;
    pulse_req(1'b0, 1'b1, '0);
    pulse_req(1'b1, 1'b1, 24'h222222);
    wait_idle();
    repeat (10) @(negedge clk);
    chk(ser_clk == 0 && latch_n == 1 && busy == 0, "R8 no activity after dropped request",
        {ser_clk, latch_n, busy}, 3'b010);

    chk(exp_q.size() == 0, "R8 pending loads", exp_q.size(), 0);
    chk(loads_seen == 7, "R8 strobe count", loads_seen, 7);
    chk(clr_seen == clr_expected, "R8 clear count", clr_seen, clr_expected);
    finish_run();
  end

endmodule